// File: doc/BRIEF.md
# DMA-to-FIFO Master Bridge

This block sits between a local DMA controller that requests the bus with a HOLD/HLDA-style handshake and the add-on FIFO port of a host bus bridge. When the DMA controller requests the bus and no host target access is pending, the bridge grants the bus. It then moves one data word per command: a read command pops a word from the bridge read FIFO and hands it to the DMA controller, and a write command captures the DMA data word and pushes it into the bridge write FIFO. After each word the bridge either goes straight back to waiting for the next command, so back-to-back transfers need no new grant, or it yields the bus.

Host target accesses take priority. When a target access is pending at the end of a word, the bridge withdraws the grant, hands the local bus back to the target path and drives bus-clear so that the DMA controller stops. Bus-clear stays active until the DMA controller drops its request. Read and write share one state register, and a parameter chooses which command wins when both are presented together.

Top module: `dma_fifo_bridge`

## Requirements
- R1: After reset the grant is low, ready_n and bclr_n are high, neither FIFO strobe is active and tgt_enable is high.
- R2: From idle the grant rises one clock after a cycle in which dma_hold is high and tgt_attn_n is high; while tgt_attn_n is low the grant is not given.
- R3: After a read command is accepted, rfifo_pop stays low while rfifo_empty is high and goes high, combinationally and for one cycle, once rfifo_empty is low.
- R4: In the cycle after a pop, dma_ready_n is low for exactly one cycle and dma_rdata equals the word present on rfifo_data during the pop.
- R5: A write command is followed by one latch cycle in which dma_wdata is captured; in the next cycle wfifo_push is high for one cycle with wfifo_data equal to the captured word and dma_ready_n low; changes of dma_wdata after the latch cycle have no effect on wfifo_data.
- R6: After a word completes with dma_hold high and tgt_attn_n high, the grant stays high and the next command is accepted without a new grant.
- R7: If tgt_attn_n is low in the cycle that completes a word while dma_hold is high, the grant drops on the next clock and dma_bclr_n goes low and stays low while dma_hold stays high.
- R8: Whenever dma_hold is low in a granted state without a strobe, the grant drops on the next clock and no FIFO strobe or ready pulse is produced.
- R9: With the default READ_FIRST=1, a cycle in which both dma_rd and dma_wr are high while waiting for a command is served as a read.
- R10: tgt_enable is high exactly while the grant is low.
- R11: While bclr_n is low the grant is not given again, even if tgt_attn_n returns high; after dma_hold drops bclr_n returns high and a new request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_hold | input | 1 | Bus request from the DMA controller |
| dma_grant | output | 1 | Bus grant to the DMA controller |
| dma_rd | input | 1 | DMA read command |
| dma_wr | input | 1 | DMA write command |
| dma_wdata | input | DATA_W | Write data from the DMA controller |
| dma_rdata | output | DATA_W | Read data to the DMA controller |
| dma_ready_n | output | 1 | Active-low word-complete strobe |
| dma_bclr_n | output | 1 | Active-low bus-clear to the DMA controller |
| tgt_attn_n | input | 1 | Active-low pending host target access |
| tgt_enable | output | 1 | High while the target path may use the local bus |
| rfifo_empty | input | 1 | Bridge read FIFO empty flag |
| rfifo_data | input | DATA_W | Bridge read FIFO output word |
| rfifo_pop | output | 1 | Read FIFO pop strobe |
| wfifo_push | output | 1 | Write FIFO push strobe |
| wfifo_data | output | DATA_W | Write FIFO input word |

## Verification
The checker watches, on every cycle, that a pop never happens on an empty FIFO, that every pop is followed by a ready pulse carrying the popped word, that strobes and ready pulses occur only under grant, that a grant only rises after a clean request, and that bus-clear excludes the grant and persists while the request stays. The exact sequencing of a write word (latch then push), the blocking of late changes to write data, command priority, back-to-back reuse of one grant and the re-grant after a yield depend on multi-cycle stimulus and are shown by the bench's directed and random scenarios.

// File: rtl/dfb_pkg.sv
package dfb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WAIT_CMD  = 3'd1,
      ST_WAIT_DATA = 3'd2,
      ST_LATCH     = 3'd3,
      ST_PUSH      = 3'd4,
      ST_SEND_RD   = 3'd5,
      ST_SEND_WR   = 3'd6,
      ST_PARK      = 3'd7
   } dfb_state_e;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_WRITE = 2'd2
   } dfb_cmd_e;
endpackage

// File: rtl/dfb_cmd_pick.sv
module dfb_cmd_pick
   import dfb_pkg::*;
#(
   parameter bit READ_FIRST = 1'b1
) (
   input  logic     rd_i,
   input  logic     wr_i,
   output dfb_cmd_e cmd_o
);
   generate
      if (READ_FIRST) begin : g_read_first
         always_comb begin
            if (rd_i)      cmd_o = CMD_READ;
            else if (wr_i) cmd_o = CMD_WRITE;
            else           cmd_o = CMD_NONE;
         end
      end else begin : g_write_first
         always_comb begin
            if (wr_i)      cmd_o = CMD_WRITE;
            else if (rd_i) cmd_o = CMD_READ;
            else           cmd_o = CMD_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/dfb_ctrl.sv
module dfb_ctrl
   import dfb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_i,
   input  logic       attn_n_i,
   input  logic       empty_i,
   input  dfb_cmd_e   cmd_i,
   output dfb_state_e state_o
);
   dfb_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            if (hold_i && attn_n_i) state_d = ST_WAIT_CMD;
         end
         ST_WAIT_CMD: begin
            if (!hold_i)                state_d = ST_IDLE;
            else if (cmd_i == CMD_READ)  state_d = ST_WAIT_DATA;
            else if (cmd_i == CMD_WRITE) state_d = ST_LATCH;
         end
         ST_WAIT_DATA: begin
            if (!hold_i)       state_d = ST_IDLE;
            else if (!empty_i) state_d = ST_SEND_RD;
         end
         ST_LATCH: begin
            state_d = hold_i ? ST_PUSH : ST_IDLE;
         end
         ST_PUSH: begin
            state_d = hold_i ? ST_SEND_WR : ST_IDLE;
         end
         ST_SEND_RD, ST_SEND_WR: begin
            if (!hold_i)        state_d = ST_IDLE;
            else if (!attn_n_i) state_d = ST_PARK;
            else                state_d = ST_WAIT_CMD;
         end
         ST_PARK: begin
            if (!hold_i) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/dfb_datapath.sv
module dfb_datapath #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_rd_i,
   input  logic [DATA_W-1:0] rd_word_i,
   input  logic              ld_wr_i,
   input  logic [DATA_W-1:0] wr_word_i,
   output logic [DATA_W-1:0] rd_word_o,
   output logic [DATA_W-1:0] wr_word_o
);
   logic [DATA_W-1:0] rd_q, wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
         wr_q <= '0;
      end else begin
         if (ld_rd_i) rd_q <= rd_word_i;
         if (ld_wr_i) wr_q <= wr_word_i;
      end
   end

   assign rd_word_o = rd_q;
   assign wr_word_o = wr_q;
endmodule

// File: rtl/dma_fifo_bridge.sv
module dma_fifo_bridge
   import dfb_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_hold,
   output logic              dma_grant,
   input  logic              dma_rd,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic [DATA_W-1:0] dma_rdata,
   output logic              dma_ready_n,
   output logic              dma_bclr_n,
   input  logic              tgt_attn_n,
   output logic              tgt_enable,
   input  logic              rfifo_empty,
   input  logic [DATA_W-1:0] rfifo_data,
   output logic              rfifo_pop,
   output logic              wfifo_push,
   output logic [DATA_W-1:0] wfifo_data
);
   localparam int DataBytes = (DATA_W + 7) / 8;

   if (DATA_W < 1) begin : g_bad_width
      $error("dma_fifo_bridge: DATA_W must be at least 1");
   end
   if (DataBytes < 1) begin : g_bad_bytes
      $error("dma_fifo_bridge: derived byte count is invalid");
   end

   dfb_cmd_e   cmd;
   dfb_state_e state;
   logic       granted;

   dfb_cmd_pick #(.READ_FIRST(READ_FIRST)) i_pick (
      .rd_i  (dma_rd),
      .wr_i  (dma_wr),
      .cmd_o (cmd)
   );

   dfb_ctrl i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (dma_hold),
      .attn_n_i (tgt_attn_n),
      .empty_i  (rfifo_empty),
      .cmd_i    (cmd),
      .state_o  (state)
   );

   always_comb begin
      case (state)
         ST_WAIT_CMD, ST_WAIT_DATA, ST_LATCH, ST_PUSH,
         ST_SEND_RD, ST_SEND_WR: granted = 1'b1;
         default:                granted = 1'b0;
      endcase
   end

   assign rfifo_pop   = (state == ST_WAIT_DATA) && dma_hold && !rfifo_empty;
   assign wfifo_push  = (state == ST_PUSH);
   assign dma_ready_n = !((state == ST_SEND_RD) || (state == ST_PUSH));
   assign dma_bclr_n  = (state != ST_PARK);
   assign dma_grant   = granted;
   assign tgt_enable  = !granted;

   dfb_datapath #(.DATA_W(DATA_W)) i_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_rd_i   (rfifo_pop),
      .rd_word_i (rfifo_data),
      .ld_wr_i   (state == ST_LATCH),
      .wr_word_i (dma_wdata),
      .rd_word_o (dma_rdata),
      .wr_word_o (wfifo_data)
   );
endmodule

// File: rtl/dma_fifo_bridge_chk.sv
module dma_fifo_bridge_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_hold,
   input logic              dma_grant,
   input logic [DATA_W-1:0] dma_rdata,
   input logic              dma_ready_n,
   input logic              dma_bclr_n,
   input logic              tgt_attn_n,
   input logic              rfifo_empty,
   input logic [DATA_W-1:0] rfifo_data,
   input logic              rfifo_pop,
   input logic              wfifo_push
);
   a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      rfifo_pop |-> !rfifo_empty);

   a_r4_ready_carries_popped: assert property (@(posedge clk) disable iff (!rst_n)
      rfifo_pop |=> (!dma_ready_n && dma_rdata == $past(rfifo_data)));

   a_r5_push_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wfifo_push |=> !wfifo_push);

   a_r8_strobes_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (rfifo_pop || wfifo_push || !dma_ready_n) |-> dma_grant);

   a_r8_release_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_grant && !dma_hold) |=> !dma_grant);

   a_r2_grant_needs_clean_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_grant) |-> ($past(dma_hold) && $past(tgt_attn_n)));

   a_r7_bclr_excludes_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_bclr_n |-> !dma_grant);

   a_r7_bclr_persists: assert property (@(posedge clk) disable iff (!rst_n)
      (!dma_bclr_n && dma_hold) |=> !dma_bclr_n);
endmodule

bind dma_fifo_bridge dma_fifo_bridge_chk #(.DATA_W(DATA_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .dma_hold    (dma_hold),
   .dma_grant   (dma_grant),
   .dma_rdata   (dma_rdata),
   .dma_ready_n (dma_ready_n),
   .dma_bclr_n  (dma_bclr_n),
   .tgt_attn_n  (tgt_attn_n),
   .rfifo_empty (rfifo_empty),
   .rfifo_data  (rfifo_data),
   .rfifo_pop   (rfifo_pop),
   .wfifo_push  (wfifo_push)
);

// File: tb/test_dma_fifo_bridge.sv
`timescale 1ns/1ps
module test_dma_fifo_bridge;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dma_hold = 1'b0;
   logic          dma_grant;
   logic          dma_rd = 1'b0;
   logic          dma_wr = 1'b0;
   logic [DW-1:0] dma_wdata = '0;
   logic [DW-1:0] dma_rdata;
   logic          dma_ready_n;
   logic          dma_bclr_n;
   logic          tgt_attn_n = 1'b1;
   logic          tgt_enable;
   logic          rfifo_empty = 1'b1;
   logic [DW-1:0] rfifo_data = '0;
   logic          rfifo_pop;
   logic          wfifo_push;
   logic [DW-1:0] wfifo_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_fifo_bridge #(.DATA_W(DW), .READ_FIRST(1'b1)) i_dma_fifo_bridge (
      .clk(clk), .rst_n(rst_n), .dma_hold(dma_hold), .dma_grant(dma_grant),
      .dma_rd(dma_rd), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
      .dma_rdata(dma_rdata), .dma_ready_n(dma_ready_n), .dma_bclr_n(dma_bclr_n),
      .tgt_attn_n(tgt_attn_n), .tgt_enable(tgt_enable),
      .rfifo_empty(rfifo_empty), .rfifo_data(rfifo_data), .rfifo_pop(rfifo_pop),
      .wfifo_push(wfifo_push), .wfifo_data(wfifo_data)
   );

   function automatic logic [DW-1:0] scramble(input logic [DW-1:0] w);
      return ~w ^ DW'(16'h5a3c);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk_idle_outputs(input string req);
      chk(dma_grant == 1'b0, req, dma_grant, 0);
      chk(tgt_enable == 1'b1, {req, " R10"}, tgt_enable, 1);
      chk(dma_ready_n == 1'b1, req, dma_ready_n, 1);
   endtask

   // from idle with attention clear: request and expect the grant (R2)
   task automatic get_grant();
      dma_hold = 1'b1;
      tgt_attn_n = 1'b1;
      step();
      chk(dma_grant == 1'b1, "R2 grant", dma_grant, 1);
      chk(tgt_enable == 1'b0, "R10 tgt_enable low while granted", tgt_enable, 0);
   endtask

   // starts at a negedge in the wait-for-command state, ends in the send state
   task automatic do_read(input logic [DW-1:0] word, input int empty_cycles);
      dma_rd = 1'b1;
      rfifo_empty = 1'b1;
      rfifo_data = word;
      step();
      for (int i = 0; i < empty_cycles; i++) begin
         chk(rfifo_pop == 1'b0, "R3 no pop while empty", rfifo_pop, 0);
         step();
      end
      rfifo_empty = 1'b0;
      #0.5;
      chk(rfifo_pop == 1'b1, "R3 pop once data present", rfifo_pop, 1);
      step();
      rfifo_empty = 1'b1;
      rfifo_data = scramble(word);
      chk(dma_ready_n == 1'b0, "R4 ready after pop", dma_ready_n, 0);
      chk(dma_rdata == word, "R4 read data", dma_rdata, word);
      chk(rfifo_pop == 1'b0, "R3 single pop", rfifo_pop, 0);
      dma_rd = 1'b0;
   endtask

   // starts at a negedge in the wait-for-command state, ends in the send state
   task automatic do_write(input logic [DW-1:0] word);
      dma_wr = 1'b1;
      dma_wdata = word;
      step();
      chk(wfifo_push == 1'b0, "R5 no push in latch cycle", wfifo_push, 0);
      step();
      dma_wdata = scramble(word);
      dma_wr = 1'b0;
      chk(wfifo_push == 1'b1, "R5 push", wfifo_push, 1);
      chk(wfifo_data == word, "R5 push data", wfifo_data, word);
      chk(dma_ready_n == 1'b0, "R5 ready with push", dma_ready_n, 0);
      step();
      chk(wfifo_push == 1'b0, "R5 push one cycle", wfifo_push, 0);
      chk(wfifo_data == word, "R5 late wdata ignored", wfifo_data, word);
   endtask

   // from a send state with attention clear: back in wait-for-command (R6)
   task automatic continue_b2b();
      step();
      chk(dma_grant == 1'b1, "R6 grant kept", dma_grant, 1);
      chk(dma_ready_n == 1'b1, "R6 ready released", dma_ready_n, 1);
   endtask

   // from a send state: attention pending -> yield, park, release (R7, R11)
   task automatic yield_and_release();
      tgt_attn_n = 1'b0;
      step();
      chk(dma_grant == 1'b0, "R7 grant dropped", dma_grant, 0);
      chk(dma_bclr_n == 1'b0, "R7 bus clear", dma_bclr_n, 0);
      chk(tgt_enable == 1'b1, "R10 tgt_enable on yield", tgt_enable, 1);
      tgt_attn_n = 1'b1;
      step();
      chk(dma_bclr_n == 1'b0, "R7 bus clear held", dma_bclr_n, 0);
      chk(dma_grant == 1'b0, "R11 no regrant while parked", dma_grant, 0);
      dma_hold = 1'b0;
      step();
      chk(dma_bclr_n == 1'b1, "R11 bus clear released", dma_bclr_n, 1);
      chk_idle_outputs("R11 idle after release");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd2718));
      step();
      // R1 reset state
      chk_idle_outputs("R1 reset");
      chk(dma_bclr_n == 1'b1, "R1 bclr_n", dma_bclr_n, 1);
      chk(rfifo_pop == 1'b0, "R1 pop", rfifo_pop, 0);
      chk(wfifo_push == 1'b0, "R1 push", wfifo_push, 0);
      rst_n = 1'b1;
      step();

      // R2 no grant while attention pending
      dma_hold = 1'b1;
      tgt_attn_n = 1'b0;
      step();
      chk(dma_grant == 1'b0, "R2 no grant under attention", dma_grant, 0);
      step();
      chk(dma_grant == 1'b0, "R2 still no grant", dma_grant, 0);
      get_grant();

      // reads and writes back to back under one grant
      do_read(16'h1234, 0);
      continue_b2b();
      do_read(16'hbeef, 3);
      continue_b2b();
      do_write(16'hc0de);
      continue_b2b();

      // R9 both commands: read wins
      dma_rd = 1'b1;
      dma_wr = 1'b1;
      rfifo_empty = 1'b0;
      rfifo_data = 16'h0f0f;
      step();
      chk(rfifo_pop == 1'b1, "R9 read served first", rfifo_pop, 1);
      step();
      dma_rd = 1'b0;
      dma_wr = 1'b0;
      rfifo_empty = 1'b1;
      chk(wfifo_push == 1'b0, "R9 no push", wfifo_push, 0);
      chk(dma_rdata == 16'h0f0f, "R9 read data", dma_rdata, 16'h0f0f);

      // R7/R11 yield then regrant
      yield_and_release();
      get_grant();

      // R8 release while waiting for read data
      dma_rd = 1'b1;
      rfifo_empty = 1'b1;
      step();
      dma_hold = 1'b0;
      dma_rd = 1'b0;
      rfifo_empty = 1'b0;
      #0.5;
      chk(rfifo_pop == 1'b0, "R8 no pop without request", rfifo_pop, 0);
      step();
      chk(dma_grant == 1'b0, "R8 grant dropped", dma_grant, 0);
      chk(dma_ready_n == 1'b1, "R8 no ready", dma_ready_n, 1);
      chk(dma_bclr_n == 1'b1, "R8 no bus clear", dma_bclr_n, 1);
      rfifo_empty = 1'b1;
      step();

      // random mix
      get_grant();
      for (int n = 0; n < 60; n++) begin
         logic [DW-1:0] w;
         w = DW'($urandom);
         if ($urandom_range(1, 0) == 1) do_read(w, int'($urandom_range(3, 0)));
         else                           do_write(w);
         if ($urandom_range(7, 0) == 0) begin
            yield_and_release();
            get_grant();
         end else begin
            continue_b2b();
         end
      end
      dma_hold = 1'b0;
      step();
      chk_idle_outputs("R8 final release");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule